// File: doc/BRIEF.md
# Chained Ternary Packet Rule Matcher

This block compares each byte of a packet stream against a table of up to 128 programmable rules. A rule matches on two things, each under its own mask: the current byte, and the index of the rule that last hit. The second match lets rules chain, so a group of rules forms a small state machine that recognises byte sequences inside a packet. When a rule hits, its index becomes the new previous hit. The block presents the rule's 5-bit action code with the index, can latch a host interrupt, and can hold off matching for a programmed number of following bytes.

The host writes rules through a plain register write port. Bytes arrive on a valid/ready stream with a start-of-packet flag. The block never applies back-pressure: `s_ready` is held high, and every cycle with `s_valid` high carries one byte. Hit reports come out as a one-cycle `hit_valid` pulse with no ready, because each byte produces at most one report. Another block carries out the action codes.

Top module: `pkt_rule_matcher`

## Requirements
- R1: After reset `hit_valid` and `irq` are 0. Every match word resets to 0xFE3E_FF00 and every control word resets to 0x0000_0002. With that table and the start index of 1, no byte produces a hit.
- R2: A rule's data test passes when `((s_data ^ dmatch) & dmask) == 0`. In the match word, dmatch is bits 7:0 and dmask is bits 15:8. A mask bit of 0 makes that data bit a don't-care.
- R3: A rule's previous-hit test passes when `((prev ^ pmatch) & pmask) == 0`. In the match word, pmatch is bits 23:17 and pmask is bits 31:25. After a hit, prev becomes the index of the winning rule, so rules can chain.
- R4: A rule whose pmask is zero never hits.
- R5: Entries 0 and 1 never hit, whatever they hold.
- R6: When several rules pass both tests on the same byte, the lowest index wins.
- R7: A hit loads the skip count from bits 21:16 of the winner's control word. While the count is N > 0, each accepted byte decrements it and is not evaluated, and prev is left unchanged. Idle cycles do not decrement the count.
- R8: A byte with `s_sop` high is evaluated with prev = 1 and a skip count of 0, whatever the earlier state was.
- R9: For a byte accepted in cycle t that hits, `hit_valid` is high in cycle t+1 for one cycle. In that cycle `hit_idx` carries the rule index and `hit_action` carries bits 6:2 of the rule's control word. A byte that does not hit gives no pulse.
- R10: `irq` sets on a hit by a rule whose control bit 7 is 1 and stays set. It clears one cycle after a status write with data bit 0 at 1. When a set and a clear fall in the same cycle, the set wins.
- R11: `s_ready` is always 1. Host writes use `cfg_sel` 0 for the match word, 1 for the control word and 2 for the status register. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 2 | Write target: 0 match word, 1 control word, 2 status |
| cfg_idx | input | 7 | Rule index for the write |
| cfg_wdata | input | 32 | Write data |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready, always 1 |
| s_sop | input | 1 | Byte is the first of a packet |
| s_data | input | 8 | Stream byte |
| hit_valid | output | 1 | One-cycle hit report |
| hit_idx | output | 7 | Index of the winning rule |
| hit_action | output | 5 | Action code of the winning rule |
| irq | output | 1 | Sticky host interrupt |

## Verification
Every result is due exactly one cycle after its cause. A byte accepted at a rising edge shows its `hit_valid`, `hit_idx` and `hit_action` on the following edge. `irq` follows the same edge as the hit that sets it or the status write that clears it. The bench drives inputs on the falling edge and, at that point, predicts the outputs the next rising edge will register. It compares those predictions at the following falling edge, so each result is checked half a cycle after it settles. The skip count is covered by bytes spaced apart with idle cycles, to show that only accepted bytes advance it.

// File: rtl/rule_pkg.sv
package rule_pkg;
  localparam int IDX_W   = 7;
  localparam int DATA_W  = 8;
  localparam int SKIP_W  = 6;
  localparam int ACT_W   = 5;
  localparam int WORD_W  = 32;

  localparam logic [1:0] SEL_MATCH = 2'd0;
  localparam logic [1:0] SEL_CTRL  = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;

  localparam logic [WORD_W-1:0] MATCH_RST = 32'hFE3E_FF00;
  localparam logic [WORD_W-1:0] CTRL_RST  = 32'h0000_0002;

  typedef struct packed {
    logic [IDX_W-1:0]  pmask;
    logic [IDX_W-1:0]  pmatch;
    logic [DATA_W-1:0] dmask;
    logic [DATA_W-1:0] dmatch;
  } rule_match_t;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic              irq_en;
    logic [ACT_W-1:0]  action;
  } rule_ctrl_t;

  function automatic rule_match_t unpack_match(input logic [WORD_W-1:0] w);
    rule_match_t r;
    r.pmask  = w[31:25];
    r.pmatch = w[23:17];
    r.dmask  = w[15:8];
    r.dmatch = w[7:0];
    return r;
  endfunction

  function automatic rule_ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
    rule_ctrl_t c;
    c.skip   = w[21:16];
    c.irq_en = w[7];
    c.action = w[6:2];
    return c;
  endfunction
endpackage

// File: rtl/rule_table.sv
module rule_table
  import rule_pkg::*;
#(
  parameter int NUM_RULES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WORD_W-1:0] cfg_wdata,
  output rule_match_t       match_o [NUM_RULES],
  output rule_ctrl_t        ctrl_o  [NUM_RULES]
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_entry
    logic sel_here;
    assign sel_here = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        match_o[g] <= unpack_match(MATCH_RST);
        ctrl_o[g]  <= unpack_ctrl(CTRL_RST);
      end else if (sel_here) begin
        if (cfg_sel == SEL_MATCH) match_o[g] <= unpack_match(cfg_wdata);
        if (cfg_sel == SEL_CTRL)  ctrl_o[g]  <= unpack_ctrl(cfg_wdata);
      end
    end
  end
endmodule

// File: rtl/rule_match_array.sv
module rule_match_array
  import rule_pkg::*;
#(
  parameter int NUM_RULES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rule_match_t       match_i [NUM_RULES],
  input  logic [DATA_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  prev_i,
  output logic              any_hit,
  output logic [IDX_W-1:0]  win_idx
);
  localparam logic [NUM_RULES-1:0] ONE = NUM_RULES'(1);

  logic [NUM_RULES-1:0] hit_vec;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    if (g < 2) begin : g_reserved
      assign hit_vec[g] = 1'b0;
    end else begin : g_rule
      logic data_ok, prev_ok, enabled;
      assign enabled = |match_i[g].pmask;
      assign data_ok = ((byte_i ^ match_i[g].dmatch) & match_i[g].dmask) == '0;
      assign prev_ok = ((prev_i ^ match_i[g].pmatch) & match_i[g].pmask) == '0;
      assign hit_vec[g] = enabled && data_ok && prev_ok;
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit_vec;

  // R6: the encoder output is a passing rule and no lower rule passes
  a_r6_winner_passes: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[win_idx]);
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & ((ONE << win_idx) - ONE)) == '0));
endmodule

// File: rtl/match_sequencer.sv
module match_sequencer
  import rule_pkg::*;
#(
  parameter logic [IDX_W-1:0] INIT_PREV = 7'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_sop,
  input  logic             any_hit,
  input  logic [IDX_W-1:0] win_idx,
  input  rule_ctrl_t       win_ctrl,
  input  logic             irq_clr,
  output logic [IDX_W-1:0] prev_eval,
  output logic             hit_valid,
  output logic [IDX_W-1:0] hit_idx,
  output logic [ACT_W-1:0] hit_action,
  output logic             irq
);
  logic [IDX_W-1:0]  prev_q;
  logic [SKIP_W-1:0] skip_q, skip_eval;
  logic              hit_now;

  assign prev_eval = s_sop ? INIT_PREV : prev_q;
  assign skip_eval = s_sop ? '0 : skip_q;
  assign hit_now   = s_valid && (skip_eval == '0) && any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= INIT_PREV;
      skip_q     <= '0;
      hit_valid  <= 1'b0;
      hit_idx    <= '0;
      hit_action <= '0;
      irq        <= 1'b0;
    end else begin
      hit_valid <= hit_now;
      if (hit_now) begin
        hit_idx    <= win_idx;
        hit_action <= win_ctrl.action;
      end
      if (s_valid) begin
        if (hit_now) begin
          prev_q <= win_idx;
          skip_q <= win_ctrl.skip;
        end else begin
          prev_q <= prev_eval;
          skip_q <= (skip_eval == '0) ? '0 : skip_eval - 1'b1;
        end
      end
      if (hit_now && win_ctrl.irq_en) irq <= 1'b1;
      else if (irq_clr)               irq <= 1'b0;
    end
  end

  // R7: a byte arriving inside a skip window never reports a hit
  a_r7_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_sop && skip_q != '0) |=> !hit_valid);
  // R9: a report needs an accepted byte in the cycle before
  a_r9_hit_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(s_valid));
  // R10: the interrupt only drops after a clear request
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/pkt_rule_matcher.sv
module pkt_rule_matcher
  import rule_pkg::*;
#(
  parameter int                NUM_RULES = 128,
  parameter logic [IDX_W-1:0]  INIT_PREV = 7'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sop,
  input  logic [DATA_W-1:0] s_data,
  output logic              hit_valid,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ACT_W-1:0]  hit_action,
  output logic              irq
);
  rule_match_t      match_w [NUM_RULES];
  rule_ctrl_t       ctrl_w  [NUM_RULES];
  logic             any_hit;
  logic [IDX_W-1:0] win_idx, prev_eval;
  rule_ctrl_t       win_ctrl;
  logic             irq_clr;

  assign s_ready  = 1'b1;
  assign irq_clr  = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];
  assign win_ctrl = ctrl_w[win_idx];

  rule_table #(.NUM_RULES(NUM_RULES)) table_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .match_o(match_w), .ctrl_o(ctrl_w)
  );

  rule_match_array #(.NUM_RULES(NUM_RULES)) array_i (
    .clk(clk), .rst_n(rst_n), .match_i(match_w), .byte_i(s_data),
    .prev_i(prev_eval), .any_hit(any_hit), .win_idx(win_idx)
  );

  match_sequencer #(.INIT_PREV(INIT_PREV)) seq_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sop(s_sop),
    .any_hit(any_hit), .win_idx(win_idx), .win_ctrl(win_ctrl),
    .irq_clr(irq_clr), .prev_eval(prev_eval), .hit_valid(hit_valid),
    .hit_idx(hit_idx), .hit_action(hit_action), .irq(irq)
  );

  // R5: reserved entries never reach the output
  a_r5_no_reserved_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_idx >= 7'd2));
endmodule

// File: tb/pkt_rule_matcher_tb_top.sv
module pkt_rule_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [6:0]  cfg_idx = 7'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        s_valid = 1'b0, s_sop = 1'b0;
  logic [7:0]  s_data = 8'd0;
  logic        s_ready, hit_valid, irq;
  logic [6:0]  hit_idx;
  logic [4:0]  hit_action;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  logic [31:0] m_match [128];
  logic [31:0] m_ctrl  [128];
  logic [6:0]  m_prev;
  logic [5:0]  m_skip;
  logic        m_irq;
  logic        e_valid;
  logic [6:0]  e_idx;
  logic [4:0]  e_act;

  always #10 clk = ~clk;

  pkt_rule_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_sop(s_sop), .s_data(s_data),
    .hit_valid(hit_valid), .hit_idx(hit_idx), .hit_action(hit_action),
    .irq(irq)
  );

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic bit rule_hits(int i, logic [7:0] d, logic [6:0] p);
    logic [31:0] w = m_match[i];
    if (i < 2) return 0;
    if (w[31:25] == 7'd0) return 0;
    return (((d ^ w[7:0]) & w[15:8]) == 8'd0) &&
           (((p ^ w[23:17]) & w[31:25]) == 7'd0);
  endfunction

  function automatic logic [31:0] mword(logic [6:0] pm, logic [6:0] pv,
                                        logic [7:0] dm, logic [7:0] dv);
    return {pm, 1'b0, pv, 1'b0, dm, dv};
  endfunction

  function automatic logic [31:0] cword(logic [5:0] sk, logic ie, logic [4:0] a);
    return {10'd0, sk, 8'd0, ie, a, 2'b00};
  endfunction

  // one cycle: compare last prediction, drive, predict the next edge
  task automatic cyc(bit v, bit sop, logic [7:0] d, bit we, logic [1:0] sel,
                     logic [6:0] idx, logic [31:0] wd);
    bit set_irq, clr_irq, found;
    logic [6:0] cp;
    logic [5:0] cs;
    @(negedge clk);
    check(req, "hit_valid", int'(hit_valid), int'(e_valid));
    if (e_valid) begin
      check(req, "hit_idx", int'(hit_idx), int'(e_idx));
      check(req, "hit_action", int'(hit_action), int'(e_act));
    end
    check(req, "irq", int'(irq), int'(m_irq));
    s_valid = v; s_sop = sop; s_data = d;
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
    e_valid = 0; set_irq = 0;
    if (v) begin
      cp = sop ? 7'd1 : m_prev;
      cs = sop ? 6'd0 : m_skip;
      found = 0;
      if (cs == 0)
        for (int i = 0; i < 128; i++)
          if (!found && rule_hits(i, d, cp)) begin
            found = 1; e_idx = 7'(i);
          end
      if (found) begin
        e_valid = 1;
        e_act   = m_ctrl[e_idx][6:2];
        m_prev  = e_idx;
        m_skip  = m_ctrl[e_idx][21:16];
        set_irq = m_ctrl[e_idx][7];
      end else begin
        m_prev = cp;
        m_skip = (cs == 0) ? 6'd0 : cs - 6'd1;
      end
    end
    clr_irq = we && sel == 2'd2 && wd[0];
    if (set_irq) m_irq = 1;
    else if (clr_irq) m_irq = 0;
    if (we && sel == 2'd0) m_match[idx] = wd;
    if (we && sel == 2'd1) m_ctrl[idx] = wd;
  endtask

  task automatic wr(logic [1:0] sel, logic [6:0] idx, logic [31:0] wd);
    cyc(0, 0, 8'd0, 1, sel, idx, wd);
  endtask
  task automatic bt(bit sop, logic [7:0] d);
    cyc(1, sop, d, 0, 2'd0, 7'd0, 32'd0);
  endtask
  task automatic idle();
    cyc(0, 0, 8'd0, 0, 2'd0, 7'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    for (int i = 0; i < 128; i++) begin
      m_match[i] = 32'hFE3E_FF00; m_ctrl[i] = 32'h0000_0002;
    end
    m_prev = 7'd1; m_skip = 0; m_irq = 0; e_valid = 0; e_idx = 0; e_act = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    check("R1", "hit_valid after reset", int'(hit_valid), 0);
    check("R1", "irq after reset", int'(irq), 0);
    check("R11", "s_ready", int'(s_ready), 1);
    bt(1, 8'h00); bt(0, 8'h00); bt(0, 8'h1F); idle();

    // R5 and R2: reserved entries match everything, rule 3 exact byte
    req = "R5";
    wr(0, 0, mword(7'h7F, 7'd1, 8'h00, 8'h00));
    wr(0, 1, mword(7'h00, 7'd0, 8'h00, 8'h00));
    bt(1, 8'h11); bt(0, 8'hA5);
    req = "R2";
    wr(0, 3, mword(7'h7F, 7'd1, 8'hFF, 8'hA5));
    wr(1, 3, cword(6'd0, 0, 5'h0C));
    bt(1, 8'hA4); bt(0, 8'hA5);
    // R3: chain 3 -> 4 -> 5 with a nibble mask on 5
    req = "R3";
    wr(0, 4, mword(7'h7F, 7'd3, 8'h00, 8'h00));
    wr(1, 4, cword(6'd0, 0, 5'h02));
    wr(0, 5, mword(7'h7F, 7'd4, 8'hF0, 8'h30));
    wr(1, 5, cword(6'd0, 0, 5'h10));
    bt(1, 8'hA5); bt(0, 8'h99); bt(0, 8'h4F); bt(0, 8'h3F); idle();
    // R4: disabled rule with all-don't-care otherwise
    req = "R4";
    wr(0, 6, mword(7'h00, 7'd5, 8'h00, 8'h00));
    wr(1, 6, cword(6'd0, 0, 5'h1F));
    bt(0, 8'h12); bt(0, 8'h34);
    // R6: rules 7 and 9 both pass after 5
    req = "R6";
    wr(0, 9, mword(7'h7F, 7'd5, 8'h00, 8'h00));
    wr(1, 9, cword(6'd0, 0, 5'h09));
    wr(0, 7, mword(7'h7F, 7'd5, 8'h00, 8'h00));
    wr(1, 7, cword(6'd0, 0, 5'h07));
    bt(1, 8'hA5); bt(0, 8'h00); bt(0, 8'h3A); bt(0, 8'h55);
    // R7: skip 3 after rule 10, idles between skipped bytes
    req = "R7";
    wr(0, 10, mword(7'h7F, 7'd1, 8'hFF, 8'h77));
    wr(1, 10, cword(6'd3, 0, 5'h18));
    wr(0, 11, mword(7'h7F, 7'd10, 8'h00, 8'h00));
    wr(1, 11, cword(6'd0, 0, 5'h1A));
    bt(1, 8'h77); bt(0, 8'h01); idle(); idle(); bt(0, 8'h02);
    idle(); bt(0, 8'h03); bt(0, 8'h04); bt(0, 8'h05);
    // R8: packet start inside a skip window
    req = "R8";
    bt(1, 8'h77); bt(0, 8'h01); bt(1, 8'h77); bt(1, 8'hA5);
    bt(0, 8'h00); bt(1, 8'h00);
    // R10: sticky interrupt, clear, set beats clear
    req = "R10";
    wr(0, 12, mword(7'h7F, 7'd1, 8'hFF, 8'hEE));
    wr(1, 12, cword(6'd0, 1, 5'h04));
    bt(1, 8'hEE); idle(); idle();
    wr(2, 0, 32'h0000_0000); idle();
    wr(2, 0, 32'h0000_0001); idle();
    s_sop = 1; cyc(1, 1, 8'hEE, 1, 2'd2, 7'd0, 32'h1); idle();
    wr(2, 0, 32'h1); idle();

    // random mix over the low rules
    req = "R9";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 8) begin
        logic [6:0] ix = 7'($urandom_range(0, 20));
        logic [6:0] pm = ($urandom_range(0, 9) == 0) ? 7'h00 :
                         ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h7F;
        wr(0, ix, mword(pm, 7'($urandom_range(1, 20)),
                        8'($urandom), 8'($urandom_range(0, 7))));
      end else if (r < 13) begin
        wr(1, 7'($urandom_range(0, 20)),
           cword(6'($urandom_range(0, 3)), 1'($urandom), 5'($urandom)));
      end else if (r < 16) begin
        wr(2, 0, 32'($urandom_range(0, 1)));
      end else if (r < 22) begin
        bt(1, 8'($urandom_range(0, 7)));
      end else if (r < 85) begin
        bt(0, 8'($urandom_range(0, 7)));
      end else begin
        idle();
      end
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule